// File: doc/BRIEF.md
# IR Carrier Frequency Detector

This block watches the raw line of an infrared receiver and measures the carrier that modulates it. Once detection is enabled, the first rising edge of the line starts a measurement. A programmable number of early carrier cycles is thrown away while the receiver front end settles. The block then times a programmable number of further cycles in 500 ns ticks. It reports the truncated mean of the cycle period and the truncated mean of the high-phase width.

An 8-bit setting controls the measurement. Its upper nibble is the number of cycles to discard and its lower nibble is the number of cycles to average. The period result carries a valid flag in its top bit. A result stays readable until a new burst begins or detection is switched off. A stretch of line silence ends a burst. Software converts the results into a frequency and a duty cycle.

Top module: `ir_carrier_det`

## Requirements
- R1: After reset, prd_o and wid_o are both 8'h00.
- R2: Time is counted in ticks of TICK_DIV clocks (500 ns by default). A carrier whose period is exactly N ticks and whose high phase is exactly H ticks reads as N and H.
- R3: The cfg_i[7:4] carrier cycles that follow the first rising edge of a measurement are left out of the average. A count of 0 discards nothing.
- R4: After the discarded cycles, the next cfg_i[3:0] cycles are averaged. Each cycle runs from one rising edge of ir_i to the next. The period result is the sum of the periods divided by the count, truncated. The width result is formed the same way from the high-phase lengths.
- R5: A cfg_i[3:0] value of 0 averages one cycle.
- R6: prd_o[7] is the valid flag and prd_o[6:0] is the mean period. wid_o[6:0] is the mean high width and wid_o[7] is always 0.
- R7: A mean period or width above 127 ticks is reported as 127.
- R8: While det_en_i is low, the valid flag clears on the next clock and activity on ir_i starts no measurement.
- R9: A rising edge that follows line silence of GAP_TICKS ticks, or that follows enabling, starts a new measurement and clears the valid flag. A valid result is held through the silence. A measurement cut short by silence never sets the valid flag.
- R10: The valid flag sets only on the rising edge that closes the last averaged cycle, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 1 | Raw IR receiver line, high during a carrier pulse |
| det_en_i | input | 1 | Carrier detection enable |
| cfg_i | input | 8 | [7:4] cycles to discard, [3:0] cycles to average |
| prd_o | output | 8 | [7] valid, [6:0] mean carrier period in ticks |
| wid_o | output | 8 | [6:0] mean high width in ticks, [7] zero |

## Verification
A table of bursts drives the averaging path with several carrier shapes. A steady carrier checks the raw tick count. Alternating periods show that the result is a truncated mean and not one sample. Discarded cycles much longer than the averaged ones would visibly skew the result if any of them leaked in. A 140-tick carrier shows the saturation at 127. Directed sequences separate the edge that closes the last cycle from the edges before it. They also separate a burst cut short by silence from one that completes, and an enabled line from a disabled one.

// File: rtl/ircd_pkg.sv
package ircd_pkg;
  localparam int unsigned RES_W   = 7;
  localparam int unsigned RES_MAX = (1 << RES_W) - 1;
  localparam int unsigned NIB_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ircd_state_e;
endpackage

// File: rtl/ircd_tick.sv
module ircd_tick #(
  parameter int unsigned TICK_DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [DW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           cnt_q <= '0;
        else if (cnt_q == DW'(TICK_DIV - 1))   cnt_q <= '0;
        else                                   cnt_q <= cnt_q + DW'(1);
      end
      assign tick_o = (cnt_q == DW'(TICK_DIV - 1));

      // R2: ticks are isolated single-cycle strobes
      a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/ircd_sync.sv
module ircd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ir_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], ir_i};
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ircd_avg.sv
module ircd_avg
  import ircd_pkg::*;
#(
  parameter int unsigned SW = 12
) (
  input  logic [SW-1:0]    sum_i,
  input  logic [NIB_W-1:0] n_i,
  output logic [RES_W-1:0] avg_o
);
  logic [SW-1:0] quo;

  always_comb begin
    quo   = sum_i / SW'(n_i);
    avg_o = (quo > SW'(RES_MAX)) ? RES_W'(RES_MAX) : quo[RES_W-1:0];
  end
endmodule

// File: rtl/ircd_meas.sv
module ircd_meas
  import ircd_pkg::*;
#(
  parameter int unsigned GAP_TICKS = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             lvl_i,
  input  logic             rise_i,
  input  logic             en_i,
  input  logic [7:0]       cfg_i,
  output logic             valid_o,
  output logic [RES_W-1:0] prd_o,
  output logic [RES_W-1:0] wid_o
);
  localparam int unsigned CW = $clog2(GAP_TICKS + 1);
  localparam int unsigned SW = CW + NIB_W;

  ircd_state_e      state_q;
  logic [CW-1:0]    p_cnt_q, h_cnt_q, p_cnt_nx, h_cnt_nx, cnt_init;
  logic [NIB_W-1:0] skip_q, n_q, done_q, n_cfg;
  logic [SW-1:0]    sum_p_q, sum_h_q, sum_p_nx, sum_h_nx;
  logic [RES_W-1:0] res_p_q, res_h_q, avg_p, avg_h;
  logic             valid_q, gap, last;

  always_comb begin
    p_cnt_nx = p_cnt_q + CW'(tick_i && (p_cnt_q != CW'(GAP_TICKS)));
    h_cnt_nx = h_cnt_q + CW'(tick_i && lvl_i && (h_cnt_q != CW'(GAP_TICKS)));
    cnt_init = CW'(tick_i);
    gap      = (p_cnt_q >= CW'(GAP_TICKS));
    sum_p_nx = sum_p_q + SW'(p_cnt_q);
    sum_h_nx = sum_h_q + SW'(h_cnt_q);
    last     = (skip_q == '0) && (({1'b0, done_q} + 5'd1) == {1'b0, n_q});
    n_cfg    = (cfg_i[3:0] == '0) ? NIB_W'(1) : cfg_i[3:0];
  end

  ircd_avg #(.SW(SW)) u_avg_p (.sum_i(sum_p_nx), .n_i(n_q), .avg_o(avg_p));
  ircd_avg #(.SW(SW)) u_avg_h (.sum_i(sum_h_nx), .n_i(n_q), .avg_o(avg_h));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      p_cnt_q <= '0;
      h_cnt_q <= '0;
      skip_q  <= '0;
      n_q     <= NIB_W'(1);
      done_q  <= '0;
      sum_p_q <= '0;
      sum_h_q <= '0;
      res_p_q <= '0;
      res_h_q <= '0;
      valid_q <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rise_i) begin
          state_q <= ST_RUN;
          valid_q <= 1'b0;
          skip_q  <= cfg_i[7:4];
          n_q     <= n_cfg;
          done_q  <= '0;
          sum_p_q <= '0;
          sum_h_q <= '0;
          p_cnt_q <= cnt_init;
          h_cnt_q <= cnt_init;
        end
        ST_RUN: begin
          if (rise_i) begin
            p_cnt_q <= cnt_init;
            h_cnt_q <= cnt_init;
            if (skip_q != '0) begin
              skip_q <= skip_q - NIB_W'(1);
            end else if (last) begin
              res_p_q <= avg_p;
              res_h_q <= avg_h;
              valid_q <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              sum_p_q <= sum_p_nx;
              sum_h_q <= sum_h_nx;
              done_q  <= done_q + NIB_W'(1);
            end
          end else if (gap) begin
            state_q <= ST_IDLE;
          end else begin
            p_cnt_q <= p_cnt_nx;
            h_cnt_q <= h_cnt_nx;
          end
        end
        ST_DONE: begin
          if (rise_i)   p_cnt_q <= cnt_init;
          else if (gap) state_q <= ST_IDLE;
          else          p_cnt_q <= p_cnt_nx;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign valid_o = valid_q;
  assign prd_o   = res_p_q;
  assign wid_o   = res_h_q;

  // R8
  a_r8_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_q);
  // R10
  a_r10_valid_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(rise_i));
  // R9
  a_r9_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && en_i && rise_i) |=> !valid_q);
  // R3
  a_r3_skip_spent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> (skip_q == '0));
  // R6
  a_r6_width_le_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (res_h_q <= res_p_q));
endmodule

// File: rtl/ir_carrier_det.sv
module ir_carrier_det
  import ircd_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 125,
  parameter int unsigned GAP_TICKS = 250,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ir_i,
  input  logic       det_en_i,
  input  logic [7:0] cfg_i,
  output logic [7:0] prd_o,
  output logic [7:0] wid_o
);
  logic             tick, lvl, rise, valid;
  logic [RES_W-1:0] prd, wid;

  ircd_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  ircd_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .ir_i(ir_i), .lvl_o(lvl), .rise_o(rise));

  ircd_meas #(.GAP_TICKS(GAP_TICKS)) u_meas (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .lvl_i(lvl),
    .rise_i(rise), .en_i(det_en_i), .cfg_i(cfg_i),
    .valid_o(valid), .prd_o(prd), .wid_o(wid));

  assign prd_o = {valid, prd};
  assign wid_o = {1'b0, wid};
endmodule

// File: tb/sim_ir_carrier_det.sv
module sim_ir_carrier_det;
  localparam int DIV = 4;
  localparam int GAP = 250;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ir = 1'b0;
  logic       en = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic [7:0] prd, wid;
  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  ir_carrier_det #(.TICK_DIV(DIV), .GAP_TICKS(GAP)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ir_i(ir), .det_en_i(en),
    .cfg_i(cfg), .prd_o(prd), .wid_o(wid));

  // {cfg, discard period, period a, period b, high}
  localparam logic [39:0] VECS [7] = '{
    40'h01_00_0A_0A_03,
    40'h04_00_0A_0D_04,
    40'h33_28_08_09_02,
    40'h20_1E_0C_0C_06,
    40'h0F_00_06_07_03,
    40'hF2_14_05_06_02,
    40'h01_00_8C_8C_14
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input int p, input int h);
    ir = 1'b1;
    repeat (h * DIV) @(negedge clk);
    ir = 1'b0;
    repeat ((p - h) * DIV) @(negedge clk);
  endtask

  task automatic close_edge(input int h);
    ir = 1'b1;
    repeat (h * DIV) @(negedge clk);
    ir = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle_gap();
    repeat ((GAP + 8) * DIV) @(negedge clk);
  endtask

  function automatic int nav(input logic [7:0] c);
    return (c[3:0] == 0) ? 1 : int'(c[3:0]);
  endfunction

  function automatic logic [7:0] exp_prd(input logic [7:0] c, input int pa, input int pb);
    int s = 0;
    int a;
    for (int j = 0; j < nav(c); j++) s += (j % 2 == 1) ? pb : pa;
    a = s / nav(c);
    if (a > 127) a = 127;
    return {1'b1, 7'(a)};
  endfunction

  task automatic burst(input logic [39:0] v);
    int skp = int'(v[31:24]);
    int pa  = int'(v[23:16]);
    int pb  = int'(v[15:8]);
    int hi  = int'(v[7:0]);
    cfg = v[39:32];
    for (int k = 0; k < int'(v[39:36]); k++) pulse(skp, skp / 2);
    for (int j = 0; j < nav(v[39:32]); j++) pulse((j % 2 == 1) ? pb : pa, hi);
    close_edge(hi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 prd reset", prd, 8'h00);
    chk("R1 wid reset", wid, 8'h00);
    rst_ni = 1'b1;
    en = 1'b1;
    repeat (5) @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 7; i++) begin
      logic [7:0] ep, ew;
      ep = exp_prd(VECS[i][39:32], int'(VECS[i][23:16]), int'(VECS[i][15:8]));
      ew = {1'b0, 7'((VECS[i][7:0] > 127) ? 127 : VECS[i][7:0])};
      burst(VECS[i]);
      chk($sformatf("R2/R3/R4/R5/R7 vec%0d period", i), prd, ep);
      chk($sformatf("R4/R6 vec%0d width", i), wid, ew);
      idle_gap();
      chk($sformatf("R9 vec%0d held through gap", i), prd, ep);
    end

    // R9 restart clears, R10 no valid before closing edge
    cfg = 8'h02;
    pulse(10, 3);
    chk("R9 new burst clears valid", {7'd0, prd[7]}, 8'h00);
    pulse(12, 3);
    chk("R10 not valid before closing edge", {7'd0, prd[7]}, 8'h00);
    close_edge(3);
    chk("R10 valid at closing edge", prd, 8'h8B);
    chk("R10 width", wid, 8'h03);
    idle_gap();

    // R9 burst cut short by silence
    cfg = 8'h04;
    pulse(10, 3);
    pulse(10, 3);
    idle_gap();
    chk("R9 aborted burst stays invalid", {7'd0, prd[7]}, 8'h00);

    // R8 disable
    burst(40'h01_00_09_09_02);
    chk("R8 pre-disable valid", prd, 8'h89);
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 disable clears valid", {7'd0, prd[7]}, 8'h00);
    burst(40'h01_00_0B_0B_04);
    chk("R8 line ignored while disabled", {7'd0, prd[7]}, 8'h00);
    chk("R8 width untouched while disabled", wid, 8'h02);
    idle_gap();
    en = 1'b1;
    repeat (4) @(negedge clk);
    burst(40'h01_00_0B_0B_04);
    chk("R8 re-enabled period", prd, 8'h8B);
    chk("R8 re-enabled width", wid, 8'h04);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule